// File: doc/BRIEF.md
# Segmented Ripple Adder with Pruned Lookahead Tree

This block is a purely combinational binary adder of parameterized width. Both operands are cut into segments of a parameterized width; the top segment is narrower when the operand width is not a whole multiple of the segment width. The bits inside a segment add through a short ripple chain. Each segment's carry-in comes from a lookahead tree, not from the segment below it.

The tree is pruned at both ends. A bottom cell sits over each segment and forms only that segment's group propagate and group generate; it has no carry logic. The cell at the top of the tree forms only carries; it has no group signals. When there are more segments than one cell can take, a middle level of cells is added. Each middle cell forms carries for its own segments and also forms group signals for the top cell. The last cell on a level may be narrower, so no input of any cell is left unused.

The block is meant for datapaths that want close to lookahead speed while paying ripple-like area in the leaves. The longest carry path is the tree followed by one segment of ripple.

Top module: `hyb_la_adder`

## Requirements
- R1: For every operand pair and carry-in, {co, sum} equals op_a + op_b + ci as an unsigned value that is one bit wider than the operands.
- R2: The carry-in ci enters at bit 0. With both operands zero and ci = 1, sum is 1 and co is 0.
- R3: A carry crosses every segment boundary. An all-ones operand plus 1, given either through the other operand or through ci, gives sum = 0 and co = 1.
- R4: A segment whose bits all propagate passes its incoming carry through unchanged. An all-ones operand plus zero gives all ones and co = 0 when ci = 0, and gives zero and co = 1 when ci = 1.
- R5: The top segment may be narrower than the others. Carries into it and out of it are correct: bit M-1 plus bit M-1 sets co, and a carry from bit M-3 reaches bit M-2.
- R6: A segment whose group generate is set delivers a carry to the next segment, whatever carry that segment receives.
- R7: The lookahead carry into each segment equals the ripple carry out of the segment below it. For example, 0x3F + 1 gives 0x40 across the first boundary.
- R8: Alternating bit patterns, where every bit propagates, add correctly with both values of ci.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | M | First operand |
| op_b | input | M | Second operand |
| ci | input | 1 | Carry into bit 0 |
| sum | output | M | Sum bits |
| co | output | 1 | Carry out of bit M-1 |

## Verification
The hardest case to reach from the ports is a carry that the tree must carry across many segments at once. In that case every segment propagates, and a single generate or the carry-in far below decides every segment carry-in. Random operands almost never produce that. The vector table therefore holds all-ones and alternating operands, which make every segment propagate. It also holds operands that place one generate at a segment's top bit or carry into the narrow top segment. Random pairs then add broad coverage.

// File: rtl/hyb_add_pkg.sv
package hyb_add_pkg;
  function automatic int cdiv(input int x, input int y);
    return (x + y - 1) / y;
  endfunction
endpackage

// File: rtl/hyb_grp_pg.sv
// Group propagate/generate of R inputs; no carry outputs.
module hyb_grp_pg #(
  parameter int R = 4
) (
  input  logic [R-1:0] p,
  input  logic [R-1:0] g,
  output logic         gp,
  output logic         gg
);
  always_comb begin
    gp = &p;
    gg = 1'b0;
    for (int i = 0; i < R; i++) begin
      logic term;
      term = g[i];
      for (int j = i + 1; j < R; j++) term = term & p[j];
      gg = gg | term;
    end
  end
endmodule

// File: rtl/hyb_la_carry.sv
// Carry-only lookahead cell: carry into each of R children.
module hyb_la_carry #(
  parameter int R = 4
) (
  input  logic [R-1:0] cp,
  input  logic [R-1:0] cg,
  input  logic         cin,
  output logic [R-1:0] carry
);
  always_comb begin
    for (int k = 0; k < R; k++) begin
      logic acc;
      acc = cin;
      for (int j = 0; j < k; j++) acc = acc & cp[j];
      for (int i = 0; i < k; i++) begin
        logic term;
        term = cg[i];
        for (int j = i + 1; j < k; j++) term = term & cp[j];
        acc = acc | term;
      end
      carry[k] = acc;
    end
  end

  always_comb begin
    if (!$isunknown({cp, cg, cin})) begin
      // R4
      all_prop_chk: assert (!(&cp) || (carry == {R{cin}}))
        else $error("all-propagate cell did not pass cin to every child");
    end
  end
endmodule

// File: rtl/hyb_ripple_seg.sv
// Bit-serial sum/carry chain of one segment.
module hyb_ripple_seg #(
  parameter int W = 4
) (
  input  logic [W-1:0] p,
  input  logic [W-1:0] g,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  always_comb begin
    c[0] = cin;
    for (int i = 0; i < W; i++) begin
      sum[i]   = p[i] ^ c[i];
      c[i + 1] = g[i] | (p[i] & c[i]);
    end
    cout = c[W];
  end
endmodule

// File: rtl/hyb_la_adder.sv
module hyb_la_adder
  import hyb_add_pkg::*;
#(
  parameter int M = 32,
  parameter int N = 6
) (
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  input  logic         ci,
  output logic [M-1:0] sum,
  output logic         co
);
  localparam int SEGS    = cdiv(M, N);
  localparam int TOP_W   = M - (SEGS - 1) * N;
  localparam int MIDS    = cdiv(SEGS, N);
  localparam int MID_TOP = SEGS - (MIDS - 1) * N;

  logic [M-1:0]    p_bit, g_bit;
  logic [SEGS-1:0] seg_p, seg_g, seg_cin, seg_co;

  assign p_bit = op_a ^ op_b;
  assign g_bit = op_a & op_b;

  for (genvar k = 0; k < SEGS; k++) begin : g_seg
    localparam int W  = (k == SEGS - 1) ? TOP_W : N;
    localparam int LO = k * N;
    hyb_grp_pg #(.R(W)) u_leaf (
      .p(p_bit[LO +: W]), .g(g_bit[LO +: W]), .gp(seg_p[k]), .gg(seg_g[k])
    );
    hyb_ripple_seg #(.W(W)) u_rip (
      .p(p_bit[LO +: W]), .g(g_bit[LO +: W]), .cin(seg_cin[k]),
      .sum(sum[LO +: W]), .cout(seg_co[k])
    );
  end

  if (MIDS == 1) begin : g_one_level
    hyb_la_carry #(.R(SEGS)) u_root (
      .cp(seg_p), .cg(seg_g), .cin(ci), .carry(seg_cin)
    );
  end else begin : g_two_level
    logic [MIDS-1:0] mid_p, mid_g, mid_cin;
    for (genvar j = 0; j < MIDS; j++) begin : g_mid
      localparam int R  = (j == MIDS - 1) ? MID_TOP : N;
      localparam int LO = j * N;
      hyb_la_carry #(.R(R)) u_carry (
        .cp(seg_p[LO +: R]), .cg(seg_g[LO +: R]), .cin(mid_cin[j]),
        .carry(seg_cin[LO +: R])
      );
      hyb_grp_pg #(.R(R)) u_grp (
        .p(seg_p[LO +: R]), .g(seg_g[LO +: R]), .gp(mid_p[j]), .gg(mid_g[j])
      );
    end
    hyb_la_carry #(.R(MIDS)) u_root (
      .cp(mid_p), .cg(mid_g), .cin(ci), .carry(mid_cin)
    );
  end

  assign co = seg_co[SEGS-1];

  always_comb begin
    if (!$isunknown({op_a, op_b, ci})) begin
      // R1
      total_sum_chk: assert ({co, sum} == ({1'b0, op_a} + {1'b0, op_b} + {{M{1'b0}}, ci}))
        else $error("sum mismatch");
      for (int k = 1; k < SEGS; k++) begin
        // R7
        seg_handoff_chk: assert (seg_cin[k] == seg_co[k-1])
          else $error("lookahead carry into segment %0d disagrees with ripple", k);
      end
      for (int k = 0; k < SEGS; k++) begin
        // R6
        seg_gen_chk: assert (!seg_g[k] || seg_co[k])
          else $error("generating segment %0d gave no carry", k);
        // R4
        seg_prop_chk: assert (!seg_p[k] || (seg_co[k] == seg_cin[k]))
          else $error("propagating segment %0d altered its carry", k);
      end
    end
  end
endmodule

// File: tb/tb_hyb_la_adder.sv
module tb_hyb_la_adder;
  localparam int M = 32;
  localparam int N = 6;

  typedef struct packed {
    logic [7:0]   req;
    logic [M-1:0] a;
    logic [M-1:0] b;
    logic         c;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{8'd1, 32'h0000_0000, 32'h0000_0000, 1'b0},  // R1 quiescent
    '{8'd2, 32'h0000_0000, 32'h0000_0000, 1'b1},  // R2
    '{8'd3, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},  // R3
    '{8'd3, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0},  // R3
    '{8'd4, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0},  // R4
    '{8'd8, 32'hAAAA_AAAA, 32'h5555_5555, 1'b1},  // R8
    '{8'd8, 32'hAAAA_AAAA, 32'h5555_5555, 1'b0},  // R8
    '{8'd5, 32'h8000_0000, 32'h8000_0000, 1'b1},  // R5
    '{8'd5, 32'h3FFF_FFFF, 32'h0000_0001, 1'b0},  // R5
    '{8'd6, 32'hFFFF_F800, 32'h0000_0800, 1'b0},  // R6
    '{8'd7, 32'h0000_003F, 32'h0000_0001, 1'b0},  // R7
    '{8'd6, 32'h0000_0800, 32'h0000_0800, 1'b1}   // R6
  };

  logic clk;
  logic [M-1:0] op_a, op_b, sum;
  logic ci, co;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  hyb_la_adder #(.M(M), .N(N)) dut (
    .op_a(op_a), .op_b(op_b), .ci(ci), .sum(sum), .co(co)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic apply(input logic [M-1:0] a, input logic [M-1:0] b,
                       input logic c, input int req);
    logic [M:0] exp;
    @(posedge clk);
    #1;
    op_a = a; op_b = b; ci = c;
    exp = {1'b0, a} + {1'b0, b} + {{M{1'b0}}, c};
    @(negedge clk);
    checks++;
    if ({co, sum} !== exp) begin
      errors++;
      $display("FAIL R%0d a=%h b=%h ci=%0d actual=%h expected=%h",
               req, a, b, c, {co, sum}, exp);
    end
  endtask

  initial begin
    op_a = '0; op_b = '0; ci = 1'b0;
    // R1: quiescent output with zero inputs
    apply('0, '0, 1'b0, 1);
    for (int i = 0; i < 12; i++) apply(VEC[i].a, VEC[i].b, VEC[i].c, int'(VEC[i].req));
    // R5: top bit plus top bit without carry-in
    apply(32'h8000_0000, 32'h8000_0000, 1'b0, 5);
    // R7: carry out of each segment boundary in turn
    for (int k = 1; k < (M + N - 1) / N; k++)
      apply((32'h1 << (k * N)) - 1, 32'h1, 1'b0, 7);
    // R1: random operands
    for (int i = 0; i < 400; i++) apply($urandom, $urandom, 1'($urandom), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule